// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Mapper

This block sits on a game cartridge for an 8-bit console and turns CPU writes into bank address lines for program memory (PRG) and character memory (CHR), plus the select line that picks one half of the console's nametable RAM. The CPU loads it one data bit per write. The upper CPU address bits choose which of four internal shift registers receives the bit. Each write shifts its target register right, and the new bit enters at the top. A register filled with N writes therefore holds the first bit written in bit 0.

There is no staging buffer. Every register drives its outputs at all times, so the bank lines move after each single write, including while a value is only partly loaded. The four registers are a 2-bit nametable arrangement register, two 4-bit CHR bank registers that cover the lower and upper 4 KiB pattern windows, and a 4-bit register that selects one of sixteen 32 KiB PRG banks. A fast system clock samples the CPU bus. A write counts once in each high phase of M2, and only when the write strobe is low and CPU A15 is high.

Top module: `serial_bank_mapper`

## Requirements
- R1: After reset all four registers are zero, so `prg_bank`, `chr_bank` and `ciram_a10` are all 0.
- R2: A write is taken when `m2` is high, `cpu_rw_n` is 0 and `cpu_a[2]` (CPU A15) is 1. It is taken exactly once per `m2` high phase, however long that phase lasts.
- R3: Writes with `cpu_a` = 3'b100 ($8000-$9FFF) shift `cpu_d0` into the 2-bit arrangement register. After two writes the first bit written is bit 0.
- R4: The arrangement code sets `ciram_a10`: code 0 gives 0, code 1 gives 1, code 2 passes `ppu_a[0]` (PPU A10), and code 3 passes `ppu_a[1]` (PPU A11).
- R5: Writes with `cpu_a` = 3'b101 load the low-window CHR register, and writes with 3'b110 load the high-window CHR register. Each is 4 bits wide and loaded right-shift, so the first of four bits lands in bit 0. Each write leaves the other register unchanged.
- R6: `chr_bank` shows the low-window register when `ppu_a[2]` (PPU A12) is 0 and the high-window register when it is 1.
- R7: Writes with `cpu_a` = 3'b111 load the 4-bit PRG register in the same way, and `prg_bank` shows it directly.
- R8: Outputs follow each individual write: after one write of 1 into a cleared 4-bit register, the output reads 4'b1000.
- R9: A write strobe with CPU A15 low, a read (`cpu_rw_n` = 1), and a strobe while `m2` is low all leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than M2 |
| rst_n | input | 1 | Active-low synchronous reset |
| m2 | input | 1 | CPU phase-2 clock |
| cpu_rw_n | input | 1 | CPU read/write strobe, 0 = write |
| cpu_a | input | 3 | CPU address A15..A13 (bit 2 = A15) |
| cpu_d0 | input | 1 | CPU data bit 0 |
| ppu_a | input | 3 | PPU address A12..A10 (bit 2 = A12) |
| prg_bank | output | PRG_W | PRG A18..A15 |
| chr_bank | output | CHR_W | CHR A15..A12 |
| ciram_a10 | output | 1 | Nametable RAM half select |

## Verification
The bench builds the block with its default widths, PRG_W = 4 and CHR_W = 4. With these widths every one of the sixteen PRG and sixteen CHR banks can be reached in four serial writes, so the bench can load distinct patterns into both CHR windows and the PRG register and read back values that are ordered by bit. The narrow registers also make the partly loaded values after one to three writes short to reach. That exposes the unbuffered behaviour and would expose a shift in the wrong direction. Holding `m2` high for many sampling clocks checks that one CPU cycle gives exactly one shift.

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper #(
  parameter int PRG_W = 4,
  parameter int CHR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m2,
  input  logic             cpu_rw_n,
  input  logic [2:0]       cpu_a,
  input  logic             cpu_d0,
  input  logic [2:0]       ppu_a,
  output logic [PRG_W-1:0] prg_bank,
  output logic [CHR_W-1:0] chr_bank,
  output logic             ciram_a10
);

  localparam int MIR_W = 2;

  logic [MIR_W-1:0] mir_q;
  logic [CHR_W-1:0] chr_lo_q, chr_hi_q;
  logic [PRG_W-1:0] prg_q;
  logic             seen_q;
  logic             take;

  assign take = m2 && !cpu_rw_n && cpu_a[2] && !seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (!m2)     seen_q <= 1'b0;
    else if (take)    seen_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mir_q    <= '0;
      chr_lo_q <= '0;
      chr_hi_q <= '0;
      prg_q    <= '0;
    end else if (take) begin
      case (cpu_a[1:0])
        2'd0: mir_q    <= {cpu_d0, mir_q[MIR_W-1:1]};
        2'd1: chr_lo_q <= {cpu_d0, chr_lo_q[CHR_W-1:1]};
        2'd2: chr_hi_q <= {cpu_d0, chr_hi_q[CHR_W-1:1]};
        default: prg_q <= {cpu_d0, prg_q[PRG_W-1:1]};
      endcase
    end
  end

  assign prg_bank = prg_q;
  assign chr_bank = ppu_a[2] ? chr_hi_q : chr_lo_q;

  always_comb begin
    case (mir_q)
      2'd0:    ciram_a10 = 1'b0;
      2'd1:    ciram_a10 = 1'b1;
      2'd2:    ciram_a10 = ppu_a[0];
      default: ciram_a10 = ppu_a[1];
    endcase
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !$past(rst_n) |-> (prg_q == '0 && chr_lo_q == '0 && chr_hi_q == '0 && mir_q == '0)); // R1

  AST_ONE_PER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (m2 && $past(m2) && $past(take)) |-> !take); // R2

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(m2 && !cpu_rw_n && cpu_a[2]) |->
      ($stable(prg_q) && $stable(chr_lo_q) && $stable(chr_hi_q) && $stable(mir_q))); // R9

  AST_CHR_LO_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(take) && $past(cpu_a[1:0]) != 2'd1 |-> $stable(chr_lo_q)); // R5

  AST_VERT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_q == 2'd2) |-> (ciram_a10 == ppu_a[0])); // R4

  AST_HORZ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_q == 2'd3) |-> (ciram_a10 == ppu_a[1])); // R4

  AST_CHR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_a[2] |-> (chr_bank == chr_hi_q)); // R6

  AST_PRG_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(take) && $past(cpu_a[1:0]) == 2'd3 |-> (prg_q[PRG_W-1] == $past(cpu_d0))); // R7

endmodule

// File: tb/sim_serial_bank_mapper.sv
module sim_serial_bank_mapper;
  localparam int PW = 4;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0, m2 = 0, cpu_rw_n = 1, cpu_d0 = 0;
  logic [2:0] cpu_a = 3'b000, ppu_a = 3'b000;
  logic [PW-1:0] prg_bank;
  logic [CW-1:0] chr_bank;
  logic ciram_a10;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_bank_mapper #(.PRG_W(PW), .CHR_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .m2(m2), .cpu_rw_n(cpu_rw_n), .cpu_a(cpu_a),
    .cpu_d0(cpu_d0), .ppu_a(ppu_a), .prg_bank(prg_bank), .chr_bank(chr_bank),
    .ciram_a10(ciram_a10));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus(input logic [2:0] a, input logic d, input logic wr, input int hold);
    @(negedge clk); cpu_a = a; cpu_d0 = d; cpu_rw_n = !wr; m2 = 0;
    @(negedge clk); m2 = 1;
    repeat (hold) @(negedge clk);
    m2 = 0; cpu_rw_n = 1;
    @(negedge clk);
  endtask

  task automatic load(input logic [2:0] a, input int val, input int n);
    for (int i = 0; i < n; i++) bus(a, val[i], 1'b1, 3);
  endtask

  task automatic t_reset;
    ppu_a = 3'b000; #1;
    chk("R1 prg", prg_bank, 0);
    chk("R1 chr", chr_bank, 0);
    chk("R1 ciram", ciram_a10, 0);
  endtask

  task automatic t_mirror;
    for (int m = 0; m < 4; m++) begin
      load(3'b100, m, 2);
      for (int p = 0; p < 8; p++) begin
        int e;
        ppu_a = p[2:0]; #1;
        e = (m == 0) ? 0 : (m == 1) ? 1 : (m == 2) ? p % 2 : (p / 2) % 2;
        chk("R3 R4 mirror", ciram_a10, e);
      end
    end
  endtask

  task automatic t_chr;
    load(3'b101, 4'b0110, 4);
    load(3'b110, 4'b1101, 4);
    ppu_a = 3'b000; #1; chk("R5 R6 chr low window", chr_bank, 6);
    ppu_a = 3'b100; #1; chk("R5 R6 chr high window", chr_bank, 13);
    load(3'b101, 4'b0001, 4);
    ppu_a = 3'b100; #1; chk("R5 high untouched", chr_bank, 13);
    ppu_a = 3'b011; #1; chk("R5 R6 chr low reload", chr_bank, 1);
  endtask

  task automatic t_prg;
    load(3'b111, 4'b1011, 4); #1; chk("R7 prg 11", prg_bank, 11);
    load(3'b111, 4'b0100, 4); #1; chk("R7 prg 4", prg_bank, 4);
    load(3'b111, 0, 4);
  endtask

  task automatic t_partial;
    bus(3'b111, 1'b1, 1'b1, 3); #1; chk("R8 one write", prg_bank, 4'b1000);
    bus(3'b111, 1'b0, 1'b1, 3); #1; chk("R8 two writes", prg_bank, 4'b0100);
    bus(3'b111, 1'b1, 1'b1, 3); #1; chk("R8 three writes", prg_bank, 4'b1010);
    load(3'b111, 0, 4);
  endtask

  task automatic t_once;
    bus(3'b111, 1'b1, 1'b1, 12); #1; chk("R2 one shift per phase", prg_bank, 4'b1000);
    bus(3'b111, 1'b1, 1'b1, 1);  #1; chk("R2 short phase shifts", prg_bank, 4'b1100);
    load(3'b111, 0, 4);
  endtask

  task automatic t_ignore;
    bus(3'b011, 1'b1, 1'b1, 3); #1; chk("R9 A15 low", prg_bank, 0);
    bus(3'b111, 1'b1, 1'b0, 3); #1; chk("R9 read", prg_bank, 0);
    @(negedge clk); cpu_a = 3'b111; cpu_d0 = 1; cpu_rw_n = 0; m2 = 0;
    repeat (4) @(negedge clk);
    cpu_rw_n = 1; @(negedge clk); #1;
    chk("R9 m2 low", prg_bank, 0);
    ppu_a = 3'b000; #1; chk("R9 chr kept", chr_bank, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_mirror;
    t_chr;
    t_prg;
    t_partial;
    t_once;
    t_ignore;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule